// File: doc/BRIEF.md
# Shared interrupt affinity router

This block holds the routing state for the shared peripheral interrupts of a multi-CPU interrupt controller. Each shared interrupt owns a 64-bit routing register on a simple register bus. Software writes a target affinity into it. The block compares that affinity against a table of the affinities of the CPUs that are present, and it moves the interrupt between the per-CPU target bitmaps in the same cycle. Downstream delivery logic reads those bitmaps; the delivery logic itself is not part of this block.

The affinity is kept as a packed 32-bit word with four 8-bit levels, and reads return it exactly as written. This holds even when the value names no present CPU. Such an interrupt is recorded with a reserved "unrouted" owner index and appears in no bitmap. It still keeps its programmed value, and the pending logic outside the block can still mark it pending. The CPU affinity table is loaded through a separate configuration port. Loading the table changes only the lookups of later writes. It never re-routes interrupts that have already been written.

The bus uses word addresses: a word address is the byte offset from the routing base divided by four. The first slot sits at byte offset 0x100, so slot `s` holds interrupt `32+s`. Its low half is at word address `0x40 + 2*s` and its high half is at `0x41 + 2*s`.

Top module: `spi_aff_router`

## Requirements
- R1: After reset, every slot has owner index 0. Bitmap row 0 (`cpu_map[NUM_SPI-1:0]`) is all ones and every other row is zero. `route_upd` is 0, and the low half of every slot reads 0, which is CPU 0's reset affinity.
- R2: A read with `bus_rd` high returns its data on `bus_rdata` in the cycle after the strobe. The low half of a slot returns the written bits 23:0 (Aff2 in 23:16, Aff1 in 15:8, Aff0 in 7:0), and bits 31:24 always read as zero.
- R3: The high half of a slot (word address bit 0 set) reads as zero. A write to it changes no owner, no bitmap and no stored value, and it produces no `route_upd` pulse.
- R4: A write to a low half whose affinity matches a present CPU `j` takes effect in the cycle after the strobe. The owner becomes `j` (`spi_owner[8*s +: 8]`) and bit `cpu_map[j*NUM_SPI + s]` is set. The slot's bit is cleared in the previous owner's row, and no other slot changes.
- R5: A write whose affinity matches no present CPU sets the owner to 0xFF and leaves the slot's bit clear in every row. A later read still returns the value as written.
- R6: A slot that is unrouted (owner 0xFF) becomes routed normally when it is rewritten with an affinity that matches a present CPU.
- R7: Word addresses below 0x40, and addresses at or above `0x40 + 2*NUM_SPI`, read as zero. Writes to them are ignored and produce no pulse.
- R8: `route_upd` is high for exactly the one cycle after each accepted write (to the low half of a valid slot), and it is low at all other times.
- R9: The CPU table resets to Aff0 equal to the CPU index, with the other levels zero, and `cfg_wr` loads the packed affinity `cfg_aff` into entry `cfg_cpu`. Loading an entry does not re-route any slot. When several entries hold the same affinity, a write routes to the lowest-numbered of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_waddr | input | ADDR_W | Word address relative to the routing base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_wr | input | 1 | CPU affinity table load strobe |
| cfg_cpu | input | clog2(NUM_CPU) | Table entry to load |
| cfg_aff | input | 32 | Packed affinity for that entry |
| route_upd | output | 1 | One-cycle pulse after each routing update |
| cpu_map | output | NUM_CPU*NUM_SPI | Per-CPU target bitmaps, row c at bits c*NUM_SPI upward |
| spi_owner | output | 8*NUM_SPI | Owner index per slot, 0xFF when unrouted |

## Verification
A routing write, its bitmap move, its owner change and its `route_upd` pulse are all due in the cycle after the write strobe. Read data is due in the cycle after the read strobe. A configuration load affects only writes that follow it. The bench drives each strobe for exactly one cycle from a falling edge, and it samples at the next falling edge, which is half a period after the edge that registers the result. It samples again one cycle later to confirm that the pulse has dropped. Ignored accesses are checked by comparing the whole bitmap and owner state against the model right after the access.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam int OWN_W = 8;
  localparam logic [OWN_W-1:0] OWN_NONE = 8'hFF;
  localparam int FIRST_SPI = 32;

  // Wide format: level 0..2 in bits 23:0, level 3 in bits 39:32.
  function automatic logic [31:0] aff_pack(input logic [63:0] wide);
    return {wide[39:32], wide[23:16], wide[15:8], wide[7:0]};
  endfunction

  function automatic logic [63:0] aff_unpack(input logic [31:0] pk);
    return {24'h0, pk[31:24], 8'h0, pk[23:16], pk[15:8], pk[7:0]};
  endfunction
endpackage

// File: rtl/spi_route_decode.sv
module spi_route_decode #(
  parameter int ADDR_W  = 12,
  parameter int NUM_SPI = 32,
  parameter int SLOT_W  = 5
) (
  input  logic [ADDR_W-1:0] waddr,
  output logic              in_win,
  output logic              upper,
  output logic [SLOT_W-1:0] slot
);
  import spi_route_pkg::*;
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(FIRST_SPI * 2);
  localparam logic [ADDR_W-2:0] LIM = (ADDR_W-1)'(NUM_SPI);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-2:0] slot_full;

  always_comb begin
    rel       = waddr - WIN;
    slot_full = rel[ADDR_W-1:1];
    in_win    = (waddr >= WIN) && (slot_full < LIM);
    upper     = rel[0];
    slot      = slot_full[SLOT_W-1:0];
  end
endmodule

// File: rtl/spi_route_table.sv
module spi_route_table #(
  parameter int NUM_CPU = 4,
  parameter int CIDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [CIDX_W-1:0]       cfg_cpu,
  input  logic [31:0]             cfg_aff,
  output logic [NUM_CPU*32-1:0]   tbl_flat
);
  logic [31:0] tbl_q [NUM_CPU];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CPU; c++) tbl_q[c] <= {24'h0, 8'(c)};
    end else if (cfg_wr) begin
      tbl_q[cfg_cpu] <= cfg_aff;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
      assign tbl_flat[c*32 +: 32] = tbl_q[c];
    end
  endgenerate
endmodule

// File: rtl/spi_route_lookup.sv
module spi_route_lookup #(
  parameter int NUM_CPU = 4
) (
  input  logic [NUM_CPU*32-1:0] tbl_flat,
  input  logic [31:0]           key,
  output logic                  hit,
  output logic [7:0]            idx
);
  logic [NUM_CPU-1:0] match;

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cmp
      assign match[c] = (tbl_flat[c*32 +: 32] == key);
    end
  endgenerate

  // Scan downward so the lowest matching entry is the one left standing.
  always_comb begin
    hit = 1'b0;
    idx = 8'hFF;
    for (int c = NUM_CPU - 1; c >= 0; c--) begin
      if (match[c]) begin
        hit = 1'b1;
        idx = 8'(c);
      end
    end
  end
endmodule

// File: rtl/spi_aff_router.sv
module spi_aff_router #(
  parameter int NUM_SPI = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  localparam int SLOT_W = $clog2(NUM_SPI),
  localparam int CIDX_W = $clog2(NUM_CPU)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_waddr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic                       cfg_wr,
  input  logic [CIDX_W-1:0]          cfg_cpu,
  input  logic [31:0]                cfg_aff,
  output logic                       route_upd,
  output logic [NUM_CPU*NUM_SPI-1:0] cpu_map,
  output logic [8*NUM_SPI-1:0]       spi_owner
);
  import spi_route_pkg::*;

  localparam logic [NUM_CPU*NUM_SPI-1:0] MAP_RST =
    {{((NUM_CPU-1)*NUM_SPI){1'b0}}, {NUM_SPI{1'b1}}};

  logic              in_win, upper;
  logic [SLOT_W-1:0] slot;
  logic [NUM_CPU*32-1:0] tbl_flat;
  logic              hit;
  logic [7:0]        hit_idx;
  logic [31:0]       new_pk;
  logic [63:0]       rd_wide;
  logic [31:0]       rd_val;
  logic              wr_acc;
  logic [OWN_W-1:0]  old_own;
  logic              wdata_unused;

  logic [31:0]       word_q [NUM_SPI];
  logic [OWN_W-1:0]  own_q  [NUM_SPI];
  logic [NUM_CPU*NUM_SPI-1:0] map_q;

  spi_route_decode #(.ADDR_W(ADDR_W), .NUM_SPI(NUM_SPI), .SLOT_W(SLOT_W)) dec_i (
    .waddr(bus_waddr), .in_win(in_win), .upper(upper), .slot(slot));

  spi_route_table #(.NUM_CPU(NUM_CPU), .CIDX_W(CIDX_W)) tbl_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cpu(cfg_cpu),
    .cfg_aff(cfg_aff), .tbl_flat(tbl_flat));

  spi_route_lookup #(.NUM_CPU(NUM_CPU)) lku_i (
    .tbl_flat(tbl_flat), .key(new_pk), .hit(hit), .idx(hit_idx));

  // Bits 31:24 of write data are not an affinity level and are dropped.
  assign wdata_unused = ^bus_wdata[31:24];

  always_comb begin
    new_pk  = aff_pack({32'h0, bus_wdata});
    wr_acc  = bus_wr && in_win && !upper;
    old_own = own_q[slot];
    rd_wide = aff_unpack(word_q[slot]);
    if (!in_win)    rd_val = 32'h0;
    else if (upper) rd_val = rd_wide[63:32];
    else            rd_val = rd_wide[31:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SPI; s++) begin
        word_q[s] <= 32'h0;
        own_q[s]  <= '0;
      end
      map_q     <= MAP_RST;
      route_upd <= 1'b0;
      bus_rdata <= 32'h0;
    end else begin
      route_upd <= wr_acc;
      if (bus_rd) bus_rdata <= rd_val;
      if (wr_acc) begin
        word_q[slot] <= new_pk;
        own_q[slot]  <= hit ? hit_idx : OWN_NONE;
        for (int c = 0; c < NUM_CPU; c++) begin
          if (old_own == 8'(c)) map_q[c*NUM_SPI + int'(slot)] <= 1'b0;
          if (hit && hit_idx == 8'(c)) map_q[c*NUM_SPI + int'(slot)] <= 1'b1;
        end
      end
    end
  end

  assign cpu_map = map_q;

  generate
    for (genvar s = 0; s < NUM_SPI; s++) begin : g_own
      assign spi_owner[8*s +: 8] = own_q[s];
    end
  endgenerate
endmodule

// File: rtl/spi_aff_router_chk.sv
module spi_aff_router_chk #(
  parameter int NUM_SPI = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_waddr,
  input logic                       route_upd,
  input logic [NUM_CPU*NUM_SPI-1:0] cpu_map,
  input logic [8*NUM_SPI-1:0]       spi_owner
);
  localparam int WIN = 64;
  localparam logic [NUM_CPU*NUM_SPI-1:0] MAP_RST =
    {{((NUM_CPU-1)*NUM_SPI){1'b0}}, {NUM_SPI{1'b1}}};

  logic acc;
  always_comb begin
    acc = bus_wr && !bus_waddr[0] && (int'(bus_waddr) >= WIN) &&
          (((int'(bus_waddr) - WIN) / 2) < NUM_SPI);
  end

  // R8
  upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    route_upd == $past(acc));

  // R3 R7
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !acc) |=> ($stable(cpu_map) && $stable(spi_owner)));

  // R1
  reset_route_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cpu_map == MAP_RST));

  generate
    for (genvar s = 0; s < NUM_SPI; s++) begin : g_col
      logic [NUM_CPU-1:0] col;
      logic [7:0]         own;
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_bit
        assign col[c] = cpu_map[c*NUM_SPI + s];
      end
      assign own = spi_owner[8*s +: 8];

      // R4
      single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col));

      // R5
      unrouted_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (own == 8'hFF) |-> (col == '0));

      // R4
      owner_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(own) < NUM_CPU) |-> ($countones(col) == 1 && ((col >> own) & 1) == 1));
    end
  endgenerate
endmodule

bind spi_aff_router spi_aff_router_chk #(
  .NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/spi_aff_router_tb_top.sv
module spi_aff_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, cfg_wr = 1'b0;
  logic [AW-1:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0, cfg_aff = '0;
  logic [1:0]  cfg_cpu = '0;
  logic [31:0] bus_rdata;
  logic        route_upd;
  logic [NC*NS-1:0] cpu_map;
  logic [8*NS-1:0]  spi_owner;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_word [NS];
  logic [7:0]  m_own  [NS];
  logic [31:0] m_tbl  [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_aff_router #(.NUM_SPI(NS), .NUM_CPU(NC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_wr(cfg_wr), .cfg_cpu(cfg_cpu), .cfg_aff(cfg_aff),
    .route_upd(route_upd), .cpu_map(cpu_map), .spi_owner(spi_owner));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    logic [NC*NS-1:0] em;
    logic [8*NS-1:0]  eo;
    em = '0;
    for (int s = 0; s < NS; s++) begin
      eo[8*s +: 8] = m_own[s];
      if (m_own[s] != 8'hFF) em[int'(m_own[s])*NS + s] = 1'b1;
    end
    checks++;
    if (cpu_map !== em) begin
      errors++;
      $display("FAIL %s map: actual %h expected %h", req, cpu_map, em);
    end
    checks++;
    if (spi_owner !== eo) begin
      errors++;
      $display("FAIL %s owner: actual %h expected %h", req, spi_owner, eo);
    end
  endtask

  function automatic logic [AW-1:0] lo_addr(input int s);
    return AW'(64 + 2*s);
  endfunction

  task automatic model_write(input int s, input logic [31:0] v);
    logic [31:0] pk;
    pk = {8'h00, v[23:0]};
    m_word[s] = pk;
    m_own[s]  = 8'hFF;
    for (int c = NC - 1; c >= 0; c--) if (m_tbl[c] == pk) m_own[s] = 8'(c);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input bit accepted, input string req);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    check({req, " R8 pulse"}, {31'h0, route_upd}, {31'h0, accepted});
    check_state(req);
    @(negedge clk);
    check("R8 pulse drop", {31'h0, route_upd}, 32'h0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_waddr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic cfg_load(input int c, input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_cpu = 2'(c); cfg_aff = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_tbl[c] = v;
  endtask

  task automatic t_reset;
    for (int s = 0; s < NS; s++) begin m_word[s] = 0; m_own[s] = 0; end
    for (int c = 0; c < NC; c++) m_tbl[c] = 32'(c);
    check("R1 upd", {31'h0, route_upd}, 32'h0);
    check_state("R1");
    bus_read(lo_addr(0), 32'h0, "R1 read slot0");
    bus_read(lo_addr(NS-1), 32'h0, "R1 read last");
  endtask

  task automatic t_route;
    model_write(5, 32'h0000_0002);
    bus_write(lo_addr(5), 32'h0000_0002, 1, "R4 to cpu2");
    model_write(5, 32'hAB00_0003);
    bus_write(lo_addr(5), 32'hAB00_0003, 1, "R4 move to cpu3");
    bus_read(lo_addr(5), 32'h0000_0003, "R2 readback top byte zero");
  endtask

  task automatic t_unrouted;
    model_write(7, 32'h0001_0203);
    bus_write(lo_addr(7), 32'h0001_0203, 1, "R5 no cpu");
    check("R5 owner", {24'h0, spi_owner[8*7 +: 8]}, 32'hFF);
    bus_read(lo_addr(7), 32'h0001_0203, "R5 readback as written");
  endtask

  task automatic t_table;
    cfg_load(1, 32'h0001_0203);
    check_state("R9 load no reroute");
    model_write(7, 32'h0001_0203);
    bus_write(lo_addr(7), 32'h0001_0203, 1, "R6 reroute to cpu1");
    check("R6 owner", {24'h0, spi_owner[8*7 +: 8]}, 32'h1);
    cfg_load(3, 32'h0000_0002);
    check_state("R9 dup load no reroute");
    model_write(9, 32'h0000_0002);
    bus_write(lo_addr(9), 32'h0000_0002, 1, "R9 lowest wins");
    check("R9 owner", {24'h0, spi_owner[8*9 +: 8]}, 32'h2);
    model_write(5, 32'h0000_0000);
    bus_write(lo_addr(5), 32'h0000_0000, 1, "R4 old owner cleared");
  endtask

  task automatic t_upper;
    bus_write(lo_addr(7) + 1, 32'h0000_0000, 0, "R3 upper write");
    bus_read(lo_addr(7) + 1, 32'h0, "R3 upper read");
    bus_read(lo_addr(7), m_word[7], "R3 low half kept");
  endtask

  task automatic t_outside;
    bus_write(AW'(63), 32'h0000_0001, 0, "R7 below window");
    bus_read(AW'(63), 32'h0, "R7 below read");
    bus_write(lo_addr(NS), 32'h0000_0001, 0, "R7 above window");
    bus_read(lo_addr(NS), 32'h0, "R7 above read");
    model_write(NS-1, 32'h0001_0203);
    bus_write(lo_addr(NS-1), 32'h0001_0203, 1, "R4 last slot");
    bus_read(lo_addr(NS-1), 32'h0001_0203, "R2 last slot read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_route;
    t_unrouted;
    t_table;
    t_upper;
    t_outside;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule